// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host side of a four-wire link to an eight-channel, 12-bit successive-approximation converter. From the system clock it makes an active-low chip select and a serial clock at the system rate divided by `DIV`. The serial clock idles high. Each frame is made of one or more 16-clock conversion slots placed back to back. In every slot the block shifts out a control word that names the channel for the next conversion, and it collects the 12-bit result that the converter returns.

The channels come from a scan list of up to eight 3-bit entries, taken in order. A converter applies the address in one slot to the conversion of the following slot. For that reason each result carries the channel that was addressed one slot earlier. The first result after reset comes from an unknown channel and is dropped. Results are sent on a valid/ready port. Frames start back to back while `enable` is high. Between frames, chip select stays high for at least one full serial-clock period.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: While reset is asserted and while no frame is running, `cs_n` and `sclk` are both 1. After reset, `res_valid` is 0. `sclk` is never low while `cs_n` is high.
- R2: Inside a frame, every transition of `cs_n` and `sclk` is DIV/2 system clocks after the previous one. This covers the first falling edge after `cs_n` falls and the rise of `cs_n` after the last rising edge.
- R3: A frame contains exactly 16*L rising `sclk` edges. L is `frame_len`, sampled when the frame starts: 0 is treated as 1, and values above MAX_SLOTS are treated as MAX_SLOTS.
- R4: Between frames, `cs_n` is high for at least DIV system clocks. A frame begins only while `enable` is 1.
- R5: `adc_din` changes only together with a falling `sclk` edge. Across the 16 falling edges of a slot it carries a 16-bit word, MSB first. Bits 13:11 hold the channel and every other bit is 0.
- R6: The channel in successive slots follows `scan_list` entries 0, 1, …, `scan_len`-1, then wraps to 0. Entry i sits at bits [3i+2:3i]. A reset restarts the list at entry 0.
- R7: `adc_dout` is sampled at each rising `sclk` edge. The bits from rising edges 5 to 16 of a slot form the result, MSB first. The bits from edges 1 to 4 are discarded.
- R8: A result is tagged on `res_chan` with the channel sent in the previous slot, including when that slot was in an earlier frame. The first slot after reset produces no result.
- R9: `res_valid` with its data stays unchanged until `res_ready` is 1. A newer result replaces one that has not been accepted.
- R10: `adc_dout` has no effect while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new frames to start |
| frame_len | input | $clog2(MAX_SLOTS+1) | Conversion slots per frame |
| scan_len | input | $clog2(SCAN_DEPTH+1) | Number of active scan-list entries |
| scan_list | input | SCAN_DEPTH*3 | Packed channel list, entry i at [3i+2:3i] |
| adc_dout | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial control word to the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 12 | Conversion result |
| res_chan | output | 3 | Channel the result belongs to |

## Verification
The bench model plays the converter. Each result it returns encodes both the converted channel and a running count, so a result tagged with the wrong channel cannot pass, and neither can a missing or repeated slot. Three scan-list and frame-length settings are used. One-slot frames with a three-entry list check the cross-frame tag and the reset drop. Eight-slot frames with a full list check that continuous slots keep their order and that the list wraps. Five-slot frames with a two-entry list run while `res_ready` toggles and during a long stall, which separates holding a result from overwriting it. Outside frames the model drives toggling data, so any sampling while `cs_n` is high corrupts a result.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int SLOT_LEN   = 16;
  localparam int BIT_W      = $clog2(SLOT_LEN);
  localparam int LEAD_ZEROS = 4;
  localparam int RES_W      = 12;
  localparam int CH_W       = 3;
  localparam int WORD_W     = 16;
  localparam int ADDR_LSB   = 11;

  typedef logic [CH_W-1:0]  chan_t;
  typedef logic [RES_W-1:0] res_t;

  function automatic logic [WORD_W-1:0] ctrl_word(chan_t ch);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ADDR_LSB +: CH_W] = ch;
    return w;
  endfunction
endpackage

// File: rtl/sadc_timing.sv
module sadc_timing
  import sadc_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int MAX_SLOTS = 8,
  parameter int FLW       = $clog2(MAX_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [FLW-1:0]   frame_len,
  output logic             cs_n,
  output logic             sclk,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic [BIT_W-1:0] bit_idx
);
  localparam int HALF = DIV / 2;
  localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GCW  = $clog2(DIV + 1);

  typedef enum logic {ST_GAP, ST_FRAME} st_t;

  st_t              st_q;
  logic [HCW-1:0]   half_q;
  logic [GCW-1:0]   gap_q;
  logic [BIT_W-1:0] bit_q;
  logic [FLW-1:0]   slot_q, nslot_q, flen_eff;
  logic             done_q, cs_q, sclk_q;
  logic             tick;

  assign tick     = (half_q == HCW'(HALF - 1));
  assign fall_evt = (st_q == ST_FRAME) && tick && sclk_q && !done_q;
  assign rise_evt = (st_q == ST_FRAME) && tick && !sclk_q;
  assign cs_n     = cs_q;
  assign sclk     = sclk_q;
  assign bit_idx  = bit_q;

  always_comb begin
    if (frame_len == '0)                    flen_eff = FLW'(1);
    else if (frame_len > FLW'(MAX_SLOTS))   flen_eff = FLW'(MAX_SLOTS);
    else                                    flen_eff = frame_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_GAP;
      half_q  <= '0;
      gap_q   <= '0;
      bit_q   <= '0;
      slot_q  <= '0;
      nslot_q <= FLW'(1);
      done_q  <= 1'b0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
    end else if (st_q == ST_GAP) begin
      if (gap_q != GCW'(DIV)) gap_q <= gap_q + GCW'(1);
      if (gap_q == GCW'(DIV) && enable) begin
        st_q    <= ST_FRAME;
        cs_q    <= 1'b0;
        half_q  <= '0;
        bit_q   <= '0;
        slot_q  <= '0;
        nslot_q <= flen_eff;
        done_q  <= 1'b0;
      end
    end else begin
      half_q <= tick ? '0 : half_q + HCW'(1);
      if (tick) begin
        if (sclk_q) begin
          if (done_q) begin
            cs_q  <= 1'b1;
            st_q  <= ST_GAP;
            gap_q <= GCW'(1);
          end else begin
            sclk_q <= 1'b0;
          end
        end else begin
          sclk_q <= 1'b1;
          if (bit_q == BIT_W'(SLOT_LEN - 1)) begin
            bit_q <= '0;
            if (slot_q == nslot_q - FLW'(1)) done_q <= 1'b1;
            else slot_q <= slot_q + FLW'(1);
          end else begin
            bit_q <= bit_q + BIT_W'(1);
          end
        end
      end
    end
  end

  // R1: clock parked high whenever chip select is high
  a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> sclk_q);
  // R2: the clock only falls inside a frame
  a_r2_fall_in_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_q) |-> !cs_q);
  // R3: a frame closes only after its last slot completed
  a_r3_whole_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_q) |-> ($past(done_q) && bit_q == '0));
  // R4: full gap before a frame starts
  a_r4_gap_before_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_q) |-> ($past(gap_q) == GCW'(DIV) && $past(enable)));
endmodule

// File: rtl/sadc_chan_seq.sv
module sadc_chan_seq
  import sadc_pkg::*;
#(
  parameter int SCAN_DEPTH = 8,
  parameter int SLW        = $clog2(SCAN_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SLW-1:0]             scan_len,
  input  logic [SCAN_DEPTH*CH_W-1:0] scan_list,
  input  logic                       slot_start,
  input  logic                       slot_end,
  output chan_t                      cur_ch,
  output chan_t                      prev_ch,
  output logic                       have_prev
);
  localparam int PW = (SCAN_DEPTH > 1) ? $clog2(SCAN_DEPTH) : 1;

  chan_t          entry [SCAN_DEPTH];
  logic [PW-1:0]  ptr_q;
  logic [SLW-1:0] len_eff;
  logic           wrap;

  for (genvar i = 0; i < SCAN_DEPTH; i++) begin : g_entry
    assign entry[i] = scan_list[i*CH_W +: CH_W];
  end

  always_comb begin
    if (scan_len == '0)                      len_eff = SLW'(1);
    else if (scan_len > SLW'(SCAN_DEPTH))    len_eff = SLW'(SCAN_DEPTH);
    else                                     len_eff = scan_len;
  end

  assign wrap = (SLW'(ptr_q) + SLW'(1)) >= len_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      cur_ch    <= '0;
      prev_ch   <= '0;
      have_prev <= 1'b0;
    end else begin
      if (slot_start) begin
        cur_ch <= entry[ptr_q];
        ptr_q  <= wrap ? '0 : ptr_q + PW'(1);
      end
      if (slot_end) begin
        prev_ch   <= cur_ch;
        have_prev <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sadc_rx.sv
module sadc_rx
  import sadc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_evt,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             adc_dout,
  input  logic             have_prev,
  input  chan_t            prev_ch,
  input  logic             res_ready,
  output logic             res_valid,
  output res_t             res_data,
  output chan_t            res_chan
);
  res_t sh_q;
  logic keep_bit, slot_end;

  assign keep_bit = rise_evt && (bit_idx >= BIT_W'(LEAD_ZEROS));
  assign slot_end = rise_evt && (bit_idx == BIT_W'(SLOT_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      if (keep_bit) sh_q <= {sh_q[RES_W-2:0], adc_dout};
      if (slot_end && have_prev) begin
        res_valid <= 1'b1;
        res_data  <= {sh_q[RES_W-2:0], adc_dout};
        res_chan  <= prev_ch;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R9: a pending result is not withdrawn without a handshake
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> res_valid);
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
  import sadc_pkg::*;
#(
  parameter int  DIV        = 4,
  parameter int  MAX_SLOTS  = 8,
  parameter int  SCAN_DEPTH = 8,
  localparam int FLW        = $clog2(MAX_SLOTS + 1),
  localparam int SLW        = $clog2(SCAN_DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic [FLW-1:0]               frame_len,
  input  logic [SLW-1:0]               scan_len,
  input  logic [SCAN_DEPTH*CH_W-1:0]   scan_list,
  input  logic                         adc_dout,
  output logic                         cs_n,
  output logic                         sclk,
  output logic                         adc_din,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic [RES_W-1:0]             res_data,
  output logic [CH_W-1:0]              res_chan
);
  logic             fall_evt, rise_evt, slot_start, slot_end, have_prev;
  logic [BIT_W-1:0] bit_idx;
  chan_t            cur_ch, prev_ch;
  logic [WORD_W-1:0] word;

  sadc_timing #(.DIV(DIV), .MAX_SLOTS(MAX_SLOTS), .FLW(FLW)) u_timing (
    .clk(clk), .rst(rst), .enable(enable), .frame_len(frame_len),
    .cs_n(cs_n), .sclk(sclk), .fall_evt(fall_evt), .rise_evt(rise_evt),
    .bit_idx(bit_idx)
  );

  assign slot_start = fall_evt && (bit_idx == '0);
  assign slot_end   = rise_evt && (bit_idx == BIT_W'(SLOT_LEN - 1));

  sadc_chan_seq #(.SCAN_DEPTH(SCAN_DEPTH), .SLW(SLW)) u_seq (
    .clk(clk), .rst(rst), .scan_len(scan_len), .scan_list(scan_list),
    .slot_start(slot_start), .slot_end(slot_end),
    .cur_ch(cur_ch), .prev_ch(prev_ch), .have_prev(have_prev)
  );

  sadc_rx u_rx (
    .clk(clk), .rst(rst), .rise_evt(rise_evt), .bit_idx(bit_idx),
    .adc_dout(adc_dout), .have_prev(have_prev), .prev_ch(prev_ch),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan)
  );

  // channel bits are sent after the slot-start load, bit 15 is always zero
  assign word = ctrl_word(cur_ch);

  always_ff @(posedge clk) begin
    if (rst)           adc_din <= 1'b0;
    else if (fall_evt) adc_din <= word[BIT_W'(WORD_W - 1) - bit_idx];
  end

  // R5: the data line only moves with a falling clock
  a_r5_din_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(adc_din) |-> $fell(sclk));
  // R8: no result before a slot with a known channel has finished
  a_r8_first_dropped: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> $past(have_prev));
endmodule

// File: tb/sadc_frame_ctrl_tb.sv
module sadc_frame_ctrl_tb;
  localparam int DIV = 4;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [3:0]  frame_len = 4'd1;
  logic [3:0]  scan_len = 4'd1;
  logic [23:0] scan_list = '0;
  logic        adc_dout;
  logic        cs_n, sclk, adc_din, res_valid;
  logic        res_ready = 1'b1;
  logic [11:0] res_data;
  logic [2:0]  res_chan;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sadc_frame_ctrl u_dut (
    .clk(clk), .rst(rst), .enable(enable), .frame_len(frame_len),
    .scan_len(scan_len), .scan_list(scan_list), .adc_dout(adc_dout),
    .cs_n(cs_n), .sclk(sclk), .adc_din(adc_din), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_chan(res_chan)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model and reference, all evaluated at the falling system edge
  int  sl[8];
  int  slen = 1, flen = 1;
  int  cyc = 0, last_evt = 0, gap = 0, rises = 0;
  int  fall_k = 0, rise_k = 0, bptr = 0, conv_ch = 0, conv_cnt = 0, hs_cnt = 0;
  bit  first = 1'b1, prev_cs = 1'b1, prev_sclk = 1'b1, prev_stall = 1'b0;
  logic [11:0] cur_val = '0;
  logic [15:0] win = '0;
  logic sdo_m = 1'b0;
  logic junk = 1'b0;
  int  qd[$];
  int  qc[$];

  // R10: toggling data outside frames
  assign adc_dout = cs_n ? junk : sdo_m;

  always @(negedge clk) begin
    cyc++;
    junk = ~junk;
    if (rst) begin
      fall_k = 0; rise_k = 0; bptr = 0; conv_ch = 0; rises = 0; gap = 0;
      first = 1'b1; prev_cs = 1'b1; prev_sclk = 1'b1; prev_stall = 1'b0;
      qd.delete(); qc.delete();
    end else begin
      check(!(cs_n && !sclk), "R1", "sclk low with cs_n high", int'(sclk), 1);
      if (cs_n) gap++;
      if (prev_cs && !cs_n) begin
        check(gap >= DIV, "R4", "gap cycles", gap, DIV);
        gap = 0; rises = 0; last_evt = cyc;
      end else if ((!prev_cs && cs_n) || (prev_sclk != sclk)) begin
        check(cyc - last_evt == HALF, "R2", "edge spacing", cyc - last_evt, HALF);
        last_evt = cyc;
      end
      if (!prev_cs && cs_n)
        check(rises == 16 * flen, "R3", "rising edges in frame", rises, 16 * flen);
      if (prev_sclk && !sclk && !cs_n) begin
        fall_k = fall_k % 16 + 1;
        if (fall_k == 1) begin
          cur_val = {3'(conv_ch), 9'(conv_cnt)};
          conv_cnt++;
        end
        sdo_m = (fall_k <= 4) ? 1'b0 : cur_val[16 - fall_k];
      end
      if (!prev_sclk && sclk && !cs_n) begin
        win = {win[14:0], adc_din};
        rises++;
        rise_k++;
        if (rise_k == 16) begin
          check((win & ~16'h3800) == 16'h0, "R5", "control word spare bits", int'(win), int'(win & 16'h3800));
          check(int'(win[13:11]) == sl[bptr], "R6", "channel in word", int'(win[13:11]), sl[bptr]);
          bptr = (bptr + 1) % slen;
          if (!first) begin
            if (qd.size() > 0) begin void'(qd.pop_front()); void'(qc.pop_front()); end
            qd.push_back(int'(cur_val));
            qc.push_back(conv_ch);
          end
          first = 1'b0;
          conv_ch = int'(win[13:11]);
          rise_k = 0;
        end
      end
      if (prev_stall)
        check(res_valid == 1'b1, "R9", "valid held while stalled", int'(res_valid), 1);
      prev_stall = res_valid && !res_ready;
      if (res_valid && res_ready) begin
        if (qd.size() == 0) begin
          check(1'b0, "R8", "unexpected result", int'(res_data), -1);
        end else begin
          check(int'(res_data) == qd[0], "R7 R10", "result data", int'(res_data), qd[0]);
          check(int'(res_chan) == qc[0], "R8", "result channel", int'(res_chan), qc[0]);
          void'(qd.pop_front()); void'(qc.pop_front());
        end
        hs_cnt++;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic setup(int l0, int l1, int l2, int l3, int l4, int l5, int l6, int l7,
                       int sln, int fln);
    @(posedge clk); #1;
    rst = 1'b1; enable = 1'b0; res_ready = 1'b1;
    sl[0] = l0; sl[1] = l1; sl[2] = l2; sl[3] = l3;
    sl[4] = l4; sl[5] = l5; sl[6] = l6; sl[7] = l7;
    for (int i = 0; i < 8; i++) scan_list[i*3 +: 3] = 3'(sl[i]);
    slen = sln; flen = fln;
    scan_len = 4'(sln); frame_len = 4'(fln);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; enable = 1'b1;
  endtask

  task automatic wait_results(int n, bit toggle);
    int target = hs_cnt + n;
    for (int k = 0; hs_cnt < target && k < 40000; k++) begin
      @(posedge clk); #1;
      if (toggle) res_ready = (k % 3 != 0);
    end
    check(hs_cnt >= target, "R3", "results received", hs_cnt, target);
    #1 res_ready = 1'b1;
  endtask

  task automatic drain();
    @(posedge clk); #1 enable = 1'b0;
    repeat (700) @(posedge clk);
  endtask

  initial begin
    // watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: cycles %0d expected below %0d", 150000, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    check(sclk == 1'b1, "R1", "sclk in reset", int'(sclk), 1);
    check(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);

    // single-slot frames, three-entry list: tag crosses frame boundaries
    setup(5, 2, 7, 0, 0, 0, 0, 0, 3, 1);
    wait_results(12, 1'b0);
    drain();
    // R4: with enable low no frame starts
    begin
      int seen = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (!cs_n) seen++;
      end
      check(seen == 0, "R4", "cs_n low cycles while disabled", seen, 0);
    end

    // eight-slot frames, full list with wrap
    setup(3, 0, 6, 1, 7, 2, 4, 5, 8, 8);
    wait_results(20, 1'b0);
    drain();

    // five-slot frames, two-entry list, toggling ready and a long stall
    setup(6, 1, 0, 0, 0, 0, 0, 0, 2, 5);
    wait_results(6, 1'b1);
    @(posedge clk); #1 res_ready = 1'b0;
    repeat (300) @(posedge clk);
    @(negedge clk);
    check(res_valid == 1'b1, "R9", "valid after stall", int'(res_valid), 1);
    @(posedge clk); #1 res_ready = 1'b1;
    wait_results(8, 1'b1);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule